// File: doc/BRIEF.md
# VLIW Execute Packet Dispatcher

This block sits between instruction fetch and decode in a very-long-instruction-word core. Each fetch packet is 256 bits wide and carries eight 32-bit instruction slots. Bit 0 of every instruction is a chaining bit. A 1 means the following slot runs in the same cycle. A 0 closes the current execute packet. One fetch packet can therefore hold anywhere from one to eight execute packets. The block issues one execute packet per clock. It places each instruction on the output lane that matches its slot, and a lane mask marks which lanes are live.

A fetch packet is requested only when the dispatcher holds none. It is accepted on a valid/ready style handshake and stays in place until its last execute packet has issued. Execute packets never cross from one fetch packet into the next. Padding NOPs in the tail slots issue like any other instruction. A downstream stall freezes the issue output and the scan position. A flush discards whatever remains of the held fetch packet.

Top module: `ep_dispatch`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), issue_valid is 0, chain_err is 0 and fetch_req is 1.
- R2: fetch_req is 1 exactly when no fetch packet is held and flush is low. A packet is accepted at an edge where fetch_req and fetch_valid are both 1. fetch_req stays 0 until the edge that issues that packet's last execute packet.
- R3: An execute packet starts at the current scan slot and includes each following slot while the previous slot's bit 0 is 1. It ends at the first slot whose bit 0 is 0, or at slot 7. issue_valid bit i marks slot i, so the mask is always one contiguous run of ones.
- R4: Slot i occupies fetch_data bits [32i+31:32i] and appears on issue_lanes bits [32i+31:32i]. Lanes whose issue_valid bit is 0 read as zero.
- R5: With stall and flush low, exactly one execute packet issues per clock edge. The first execute packet of an accepted fetch packet issues at the edge after the accepting edge. Scanning starts at slot 0 and moves to increasing slot numbers.
- R6: At an edge where stall is 1 and flush is 0, issue_valid, issue_lanes and the scan position do not change. Issuing resumes with the next unissued execute packet.
- R7: At an edge where flush is 1, issue_valid and issue_lanes are cleared, chain_err is cleared and the held fetch packet is dropped. fetch_req is 1 in the following cycle once flush falls.
- R8: chain_err is 1 for exactly the one cycle after the edge that issues an execute packet closed at slot 7 whose bit 0 is 1. Otherwise it is 0.
- R9: At an edge where no fetch packet is held and stall and flush are low, issue_valid becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_req | output | 1 | Ready for a new fetch packet |
| fetch_valid | input | 1 | Fetch packet present on fetch_data |
| fetch_data | input | 256 | Eight instruction slots, slot 0 in the low bits |
| stall | input | 1 | Downstream stall, holds the issue output |
| flush | input | 1 | Drop the rest of the held fetch packet |
| issue_valid | output | 8 | Per-lane valid mask of the issued execute packet |
| issue_lanes | output | 256 | Issued instructions, each on its slot lane |
| chain_err | output | 1 | One-cycle flag: slot 7 closed a packet while its chaining bit was set |

## Verification
The hardest case to reach from the ports is a stall or flush that lands in the middle of a multi-packet fetch packet. That is the only place where the saved scan position matters. Random fetch data is generated with the chaining bit set three times in four, and random stalls and flushes are laid over that traffic, so fetch packets split into mixed-length runs and interruptions land at many different slots. Directed packets add the two extremes: eight single-slot packets, and one fully chained packet that ends in a set chaining bit on slot 7.

// File: rtl/ep_dispatch_pkg.sv
package ep_dispatch_pkg;
  typedef enum logic {SLOT_EMPTY = 1'b0, SLOT_HELD = 1'b1} slot_state_e;
endpackage

// File: rtl/ep_scanner.sv
module ep_scanner #(
  parameter int LANES = 8,
  localparam int POS_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0] slot_link,
  input  logic [POS_W-1:0] pos,
  output logic [LANES-1:0] span,
  output logic [POS_W-1:0] next_pos,
  output logic             ends_fp,
  output logic             forced_close
);
  // Lanes from pos up to the first slot whose link bit is 0, or the last slot.
  function automatic logic [LANES-1:0] span_from(input logic [LANES-1:0] link,
                                                 input logic [POS_W-1:0] start);
    logic [LANES-1:0] m;
    logic open;
    m = '0;
    open = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (i >= int'(start) && open) begin
        m[i] = 1'b1;
        if (!link[i]) open = 1'b0;
      end
    end
    return m;
  endfunction

  function automatic logic [POS_W-1:0] top_index(input logic [LANES-1:0] m);
    logic [POS_W-1:0] e;
    e = '0;
    for (int i = 0; i < LANES; i++)
      if (m[i]) e = POS_W'(i);
    return e;
  endfunction

  logic [POS_W-1:0] end_idx;

  always_comb begin
    span         = span_from(slot_link, pos);
    end_idx      = top_index(span);
    next_pos     = end_idx + POS_W'(1);
    ends_fp      = span[LANES-1];
    forced_close = span[LANES-1] & slot_link[LANES-1];
  end
endmodule

// File: rtl/ep_fetch_slot.sv
module ep_fetch_slot
  import ep_dispatch_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int WORD_W = 32,
  localparam int FP_W  = LANES * WORD_W,
  localparam int POS_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             fetch_valid,
  input  logic [FP_W-1:0]  fetch_data,
  output logic             fetch_req,
  input  logic             advance,
  input  logic             ep_last,
  input  logic [POS_W-1:0] next_pos,
  output logic [FP_W-1:0]  pkt,
  output logic [POS_W-1:0] pos,
  output logic             held
);
  slot_state_e state;
  logic        accept;

  assign fetch_req = (state == SLOT_EMPTY) && !flush;
  assign accept    = fetch_req && fetch_valid;
  assign held      = (state == SLOT_HELD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SLOT_EMPTY;
      pos   <= '0;
      pkt   <= '0;
    end else if (flush) begin
      state <= SLOT_EMPTY;
      pos   <= '0;
    end else if (accept) begin
      pkt   <= fetch_data;
      state <= SLOT_HELD;
      pos   <= '0;
    end else if (advance) begin
      pos <= next_pos;
      if (ep_last) state <= SLOT_EMPTY;
    end
  end

  // R2: an accepted packet is held with the scan at slot 0
  assert_accept_loads_R2: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fetch_valid) |=> (held && pos == '0));

  // R5: the issue stage only advances while a packet is held
  assert_adv_needs_pkt_R5: assert property (@(posedge clk) disable iff (rst)
    advance |-> held);
endmodule

// File: rtl/ep_issue_stage.sv
module ep_issue_stage #(
  parameter int LANES  = 8,
  parameter int WORD_W = 32,
  localparam int FP_W  = LANES * WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             stall,
  input  logic             held,
  input  logic [FP_W-1:0]  pkt,
  input  logic [LANES-1:0] span,
  input  logic             forced_close,
  output logic             advance,
  output logic [LANES-1:0] issue_valid,
  output logic [FP_W-1:0]  issue_lanes,
  output logic             chain_err
);
  logic [FP_W-1:0] gated;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign gated[g*WORD_W +: WORD_W] = span[g] ? pkt[g*WORD_W +: WORD_W] : '0;
  end

  assign advance = held && !stall && !flush;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      issue_valid <= '0;
      issue_lanes <= '0;
      chain_err   <= 1'b0;
    end else if (stall) begin
      chain_err <= 1'b0;
    end else if (held) begin
      issue_valid <= span;
      issue_lanes <= gated;
      chain_err   <= forced_close;
    end else begin
      issue_valid <= '0;
      issue_lanes <= '0;
      chain_err   <= 1'b0;
    end
  end

  // R6: a stall freezes the issued packet
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (stall && !flush) |=> ($stable(issue_valid) && $stable(issue_lanes)));

  // R7: a flush empties the output
  assert_flush_clear_R7: assert property (@(posedge clk) disable iff (rst)
    flush |=> (issue_valid == '0 && !chain_err));

  // R8: the error flag is a single-cycle pulse
  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    chain_err |=> !chain_err);
endmodule

// File: rtl/ep_dispatch.sv
module ep_dispatch #(
  parameter int LANES  = 8,
  parameter int WORD_W = 32,
  localparam int FP_W  = LANES * WORD_W,
  localparam int POS_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic             fetch_req,
  input  logic             fetch_valid,
  input  logic [FP_W-1:0]  fetch_data,
  input  logic             stall,
  input  logic             flush,
  output logic [LANES-1:0] issue_valid,
  output logic [FP_W-1:0]  issue_lanes,
  output logic             chain_err
);
  logic [FP_W-1:0]  pkt;
  logic [POS_W-1:0] scan_pos;
  logic [POS_W-1:0] next_pos;
  logic [LANES-1:0] slot_link;
  logic [LANES-1:0] scan_span;
  logic             held;
  logic             advance;
  logic             ends_fp;
  logic             forced_close;

  for (genvar g = 0; g < LANES; g++) begin : g_link
    assign slot_link[g] = pkt[g*WORD_W];
  end

  ep_fetch_slot #(.LANES(LANES), .WORD_W(WORD_W)) u_slot (
    .clk(clk), .rst(rst), .flush(flush),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data), .fetch_req(fetch_req),
    .advance(advance), .ep_last(ends_fp), .next_pos(next_pos),
    .pkt(pkt), .pos(scan_pos), .held(held)
  );

  ep_scanner #(.LANES(LANES)) u_scan (
    .slot_link(slot_link), .pos(scan_pos), .span(scan_span),
    .next_pos(next_pos), .ends_fp(ends_fp), .forced_close(forced_close)
  );

  ep_issue_stage #(.LANES(LANES), .WORD_W(WORD_W)) u_issue (
    .clk(clk), .rst(rst), .flush(flush), .stall(stall), .held(held),
    .pkt(pkt), .span(scan_span), .forced_close(forced_close),
    .advance(advance), .issue_valid(issue_valid),
    .issue_lanes(issue_lanes), .chain_err(chain_err)
  );

  // R3: the issued mask is one contiguous run of lanes
  assert_mask_contig_R3: assert property (@(posedge clk) disable iff (rst)
    ((issue_valid + (issue_valid & (~issue_valid + LANES'(1)))) & issue_valid) == '0);

  // R3: a held packet always yields a span that starts at the scan slot
  assert_start_slot_R3: assert property (@(posedge clk) disable iff (rst)
    held |-> scan_span[scan_pos]);

  // R2: no new fetch while an issued packet left slots behind it
  assert_no_early_req_R2: assert property (@(posedge clk) disable iff (rst)
    (issue_valid != '0 && !issue_valid[LANES-1]) |-> !fetch_req);

  // R8: the error flag comes with a packet that owns the last lane
  assert_err_last_lane_R8: assert property (@(posedge clk) disable iff (rst)
    chain_err |-> issue_valid[LANES-1]);

  // R5: the first packet issues at the edge after acceptance
  assert_first_issue_R5: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fetch_valid) ##1 (!stall && !flush) |=> issue_valid[0]);
endmodule

// File: tb/tb_ep_dispatch.sv
module tb_ep_dispatch;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fetch_valid = 1'b0;
  logic [255:0] fetch_data = '0;
  logic         stall = 1'b0;
  logic         flush = 1'b0;
  logic         fetch_req;
  logic [7:0]   issue_valid;
  logic [255:0] issue_lanes;
  logic         chain_err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ep_dispatch dut (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_valid(fetch_valid),
    .fetch_data(fetch_data), .stall(stall), .flush(flush),
    .issue_valid(issue_valid), .issue_lanes(issue_lanes), .chain_err(chain_err)
  );

  // Reference model, written from the requirements
  bit           m_held = 1'b0;
  int           m_pos = 0;
  logic [255:0] m_buf = '0;
  logic [7:0]   e_mask = '0;
  logic [255:0] e_lanes = '0;
  bit           e_err = 1'b0;

  always @(posedge clk) begin
    bit req_old;
    int e;
    int hi;
    int lo;
    req_old = !m_held && !flush;
    if (rst || flush) begin
      if (rst) m_buf = '0;
      m_held = 1'b0; m_pos = 0; e_mask = '0; e_lanes = '0; e_err = 1'b0;
    end else begin
      if (stall) begin
        e_err = 1'b0;
      end else if (m_held) begin
        e = m_pos;
        while (e < 7 && m_buf[32*e] == 1'b1) e++;
        hi = (1 << (e + 1)) - 1;
        lo = (1 << m_pos) - 1;
        e_mask = 8'(hi & ~lo);
        e_lanes = '0;
        for (int i = m_pos; i <= e; i++) e_lanes[32*i +: 32] = m_buf[32*i +: 32];
        e_err = (e == 7) && m_buf[224];
        if (e == 7) m_held = 1'b0;
        else m_pos = e + 1;
      end else begin
        e_mask = '0; e_lanes = '0; e_err = 1'b0;
      end
      if (req_old && fetch_valid) begin
        m_buf = fetch_data; m_held = 1'b1; m_pos = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock; compare every output against the model at the falling edge
  task automatic tick();
    @(negedge clk);
    if (!rst) begin
      chk(issue_valid == e_mask, "R3 mask", 256'(issue_valid), 256'(e_mask));
      chk(issue_lanes == e_lanes, "R4 lanes", issue_lanes, e_lanes);
      chk(chain_err == e_err, "R8 err", 256'(chain_err), 256'(e_err));
      chk(fetch_req == (!m_held && !flush), "R2 req", 256'(fetch_req),
          256'(!m_held && !flush));
    end
  endtask

  function automatic logic [255:0] make_pkt(input logic [7:0] links);
    logic [255:0] p;
    for (int i = 0; i < 8; i++) p[32*i +: 32] = {$urandom(), 1'b0} | 32'(links[i]);
    return p;
  endfunction

  task automatic load(input logic [255:0] p);
    fetch_data = p; fetch_valid = 1'b1;
    tick();
    fetch_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [255:0] p;
    void'($urandom(32'h5eed_1234));
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk(issue_valid == 8'h00, "R1 mask after reset", 256'(issue_valid), 256'h0);
    chk(chain_err == 1'b0, "R1 err after reset", 256'(chain_err), 256'h0);
    chk(fetch_req == 1'b1, "R1 req after reset", 256'(fetch_req), 256'h1);

    // Fully chained packet with slot 7 link set: one packet, error pulse
    load(make_pkt(8'hFF));
    tick();
    chk(issue_valid == 8'hFF, "R5 first issue after accept", 256'(issue_valid), 256'hFF);
    chk(chain_err == 1'b1, "R8 slot7 link set", 256'(chain_err), 256'h1);
    chk(fetch_req == 1'b1, "R2 request after last packet", 256'(fetch_req), 256'h1);
    tick();
    chk(chain_err == 1'b0, "R8 pulse one cycle", 256'(chain_err), 256'h0);
    chk(issue_valid == 8'h00, "R9 idle mask", 256'(issue_valid), 256'h0);

    // No links: eight single-slot packets, one per clock
    load(make_pkt(8'h00));
    for (int k = 0; k < 8; k++) begin
      tick();
      chk(issue_valid == 8'(1 << k), "R5 one packet per clock", 256'(issue_valid),
          256'(1 << k));
      chk(fetch_req == (k == 7), "R2 no request mid packet", 256'(fetch_req),
          256'(k == 7));
    end

    // Stall in the middle, then flush
    p = make_pkt(8'b0000_0001);
    load(p);
    tick();
    chk(issue_valid == 8'h03, "R3 two-slot packet", 256'(issue_valid), 256'h03);
    chk(issue_lanes == {192'b0, p[63:0]}, "R4 lane placement", issue_lanes,
        {192'b0, p[63:0]});
    stall = 1'b1;
    tick();
    tick();
    chk(issue_valid == 8'h03, "R6 stall holds mask", 256'(issue_valid), 256'h03);
    chk(issue_lanes == {192'b0, p[63:0]}, "R6 stall holds lanes", issue_lanes,
        {192'b0, p[63:0]});
    stall = 1'b0;
    tick();
    chk(issue_valid == 8'h04, "R6 resume at next slot", 256'(issue_valid), 256'h04);
    flush = 1'b1;
    tick();
    chk(issue_valid == 8'h00, "R7 flush clears mask", 256'(issue_valid), 256'h0);
    flush = 1'b0;
    #1;
    chk(fetch_req == 1'b1, "R7 request after flush", 256'(fetch_req), 256'h1);

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] links;
      for (int i = 0; i < 8; i++) links[i] = ($urandom() % 4) != 0;
      fetch_data  = make_pkt(links);
      fetch_valid = ($urandom() % 3) != 0;
      stall       = ($urandom() % 5) == 0;
      flush       = ($urandom() % 40) == 0;
      tick();
    end
    stall = 1'b0; flush = 1'b0; fetch_valid = 1'b0;
    repeat (10) tick();
    chk(issue_valid == 8'h00, "R9 idle after drain", 256'(issue_valid), 256'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule